// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level table: a directory indexed by the top ten address bits, then a table indexed by the next ten. A directory entry may map a 4 MB region on its own when large pages are enabled. Such an entry also carries eight extra physical address bits, so results reach up to 40 bits. Otherwise the walk continues to a table entry that maps a 4 KB page. Each table read goes through a request/valid memory port that may take any number of wait cycles.

Accessed and dirty flags are maintained through a compare-and-set port. The walker offers the entry value it read together with the bits to set. The port answers either with success or with a report that memory no longer holds that value. A lost race on a directory update re-reads that directory entry. A lost race on the final update restarts the whole walk. The result is a physical address, a page size flag and the combined user and write rights, or a fault with its kind. A caller starts a walk with a one-cycle start pulse and waits for the one-cycle done pulse. The results stay stable until the next walk begins.

Top module: `pw_walker`

## Requirements
- R1: The directory entry is read at ((tableBase with bits 11:0 cleared) + (virtAddr[31:22] * 4)) AND a20Mask.
- R2: An entry with bit 0 (present) clear, at either level, ends the walk with faultValid=1 and faultKind=1, and no further memory read follows.
- R3: A directory entry with bit 7 set while largePageEn=1 maps a 4 MB page, so bigPage=1 and no table read occurs. With largePageEn=0, bit 7 is ignored and the table level is walked.
- R4: For a 4 MB entry with bit 21 set, the walk ends with faultValid=1 and faultKind=2.
- R5: For a small-page directory entry whose bit 5 (accessed) is clear, a compare-and-set request of bit 5 is sent for that entry, and an entry that already has it set gets no request. On a failed request, the directory entry is read again and re-checked.
- R6: The table entry is read at ((directory entry with bits 11:0 cleared) + (virtAddr[21:12] * 4)) AND a20Mask.
- R7: userOk is the AND of bit 2 at both levels, and writeOk is the AND of bit 1 at both levels. A 4 MB page uses the directory entry alone.
- R8: The final entry gets a request to set bit 5, plus bit 6 (dirty) when accKind=1 (store; 0 is load, 2 is fetch). No request is made when those bits are already set. For a non-store access to an entry with bit 6 clear, writeOk is 0.
- R9: A failed final flag update restarts the walk with a new directory read.
- R10: For a 4 KB page, physAddr is {8'h00, entry[31:12] AND a20Mask[31:12], virtAddr[11:0]}. For a 4 MB page, it is {entry[20:13], entry[31:22] AND a20Mask[31:22], virtAddr[21:0]}.
- R11: doneStrobe lasts one cycle. memReq and flagReq are never high together, and each stays high with a stable address until memValid or flagAck arrives.
- R12: After reset, doneStrobe, memReq, flagReq and faultValid are 0 and physAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle pulse that starts a walk |
| virtAddr | input | 32 | Virtual address to translate |
| accKind | input | 2 | 0 load, 1 store, 2 fetch |
| tableBase | input | 32 | Directory base address |
| largePageEn | input | 1 | Enables 4 MB directory mappings |
| a20Mask | input | 32 | Mask ANDed into entry addresses and frames |
| memReq | output | 1 | Read request, held until memValid |
| memAddr | output | 32 | Read address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data |
| flagReq | output | 1 | Compare-and-set request, held until flagAck |
| flagAddr | output | 32 | Entry address to update |
| flagOld | output | 32 | Entry value expected in memory |
| flagSet | output | 32 | Bits to OR into the entry |
| flagAck | input | 1 | Update finished |
| flagOk | input | 1 | With flagAck: 1 when the update was applied |
| doneStrobe | output | 1 | One-cycle walk-complete pulse |
| physAddr | output | PA_W | Translated physical address |
| bigPage | output | 1 | 1 for a 4 MB page |
| userOk | output | 1 | Combined user right |
| writeOk | output | 1 | Combined write right |
| faultValid | output | 1 | Walk ended in a fault |
| faultKind | output | 2 | 1 not present, 2 reserved bit |

## Verification
The bench builds the walker with the default PA_W of 40. This puts the eight high frame bits of a 4 MB entry onto the physical address, so their placement can be checked directly. The memory model changes its latency between scenarios from zero to several wait cycles. The compare-and-set model can be made to lose one race, and it may also change the entry first. This makes both the directory re-read and the full restart observable through the sequence of read addresses. An a20Mask with bit 20 cleared reaches the masking of the directory address, the table address and the frame.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ENT_W = 32;
  localparam int BIT_P = 0;
  localparam int BIT_RW = 1;
  localparam int BIT_US = 2;
  localparam int BIT_A = 5;
  localparam int BIT_D = 6;
  localparam int BIT_PS = 7;
  localparam int BIT_LRSVD = 21;
  localparam int LHI_LSB = 13;

  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} accKind_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ABSENT = 2'd1, FLT_RSVD = 2'd2} fltKind_e;

  typedef struct packed {
    logic     latchIn;
    logic     loadDir;
    logic     loadTbl;
    logic     selTbl;
    logic     flagFin;
    logic     commitOk;
    logic     commitFlt;
    fltKind_e fltKind;
  } pwCtl_t;

  typedef struct packed {
    logic dirPresent;
    logic dirLarge;
    logic dirRsvd;
    logic dirNeedA;
    logic tblPresent;
    logic finNeedSet;
  } pwSts_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   memValid,
  input  logic   flagAck,
  input  logic   flagOk,
  input  pwSts_t sts,
  output pwCtl_t ctl,
  output logic   memReq,
  output logic   flagReq,
  output logic   doneStrobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_DRD, S_DCHK, S_DSET, S_TRD, S_TCHK, S_FIN, S_DONE
  } st_e;

  st_e st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    ctl = '0;
    memReq = 1'b0;
    flagReq = 1'b0;
    doneStrobe = 1'b0;
    case (st)
      S_IDLE: begin
        if (startReq) begin
          ctl.latchIn = 1'b1;
          nxt = S_DRD;
        end
      end
      S_DRD: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.loadDir = 1'b1;
          nxt = S_DCHK;
        end
      end
      S_DCHK: begin
        if (!sts.dirPresent) begin
          ctl.commitFlt = 1'b1;
          ctl.fltKind = FLT_ABSENT;
          nxt = S_DONE;
        end else if (sts.dirLarge) begin
          if (sts.dirRsvd) begin
            ctl.commitFlt = 1'b1;
            ctl.fltKind = FLT_RSVD;
            nxt = S_DONE;
          end else begin
            nxt = S_FIN;
          end
        end else if (sts.dirNeedA) begin
          nxt = S_DSET;
        end else begin
          nxt = S_TRD;
        end
      end
      S_DSET: begin
        flagReq = 1'b1;
        if (flagAck) nxt = flagOk ? S_TRD : S_DRD;
      end
      S_TRD: begin
        memReq = 1'b1;
        ctl.selTbl = 1'b1;
        if (memValid) begin
          ctl.loadTbl = 1'b1;
          nxt = S_TCHK;
        end
      end
      S_TCHK: begin
        if (!sts.tblPresent) begin
          ctl.commitFlt = 1'b1;
          ctl.fltKind = FLT_ABSENT;
          nxt = S_DONE;
        end else begin
          nxt = S_FIN;
        end
      end
      S_FIN: begin
        ctl.flagFin = 1'b1;
        if (!sts.finNeedSet) begin
          ctl.commitOk = 1'b1;
          nxt = S_DONE;
        end else begin
          flagReq = 1'b1;
          if (flagAck) begin
            if (flagOk) begin
              ctl.commitOk = 1'b1;
              nxt = S_DONE;
            end else begin
              nxt = S_DRD;
            end
          end
        end
      end
      S_DONE: begin
        doneStrobe = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pw_dpath.sv
module pw_dpath
  import pw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwCtl_t            ctl,
  input  logic [31:0]       virtAddr,
  input  logic [1:0]        accKind,
  input  logic [31:0]       tableBase,
  input  logic              largePageEn,
  input  logic [31:0]       a20Mask,
  input  logic [31:0]       memData,
  output pwSts_t            sts,
  output logic [31:0]       memAddr,
  output logic [31:0]       flagAddr,
  output logic [31:0]       flagOld,
  output logic [31:0]       flagSet,
  output logic [PA_W-1:0]   physAddr,
  output logic              bigPage,
  output logic              userOk,
  output logic              writeOk,
  output logic              faultValid,
  output logic [1:0]        faultKind
);
  localparam int HI_W = PA_W - ENT_W;

  logic [31:0] vaR, a20R, dirEnt, tblEnt;
  logic [19:0] baseR;
  logic        storeR, pseR;
  logic [31:0] dirAddr, tblAddr, finEnt, finSet;
  logic [PA_W-1:0] physSmall, physLarge, physNext;
  logic        userNext, writeNext;
  logic [PA_W-1:0] physR;
  logic        bigR, userR, writeR;
  fltKind_e    fltR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaR <= '0; a20R <= '0; baseR <= '0; storeR <= 1'b0; pseR <= 1'b0;
      dirEnt <= '0; tblEnt <= '0;
      physR <= '0; bigR <= 1'b0; userR <= 1'b0; writeR <= 1'b0; fltR <= FLT_NONE;
    end else begin
      if (ctl.latchIn) begin
        vaR <= virtAddr;
        a20R <= a20Mask;
        baseR <= tableBase[31:12];
        storeR <= (accKind == ACC_STORE);
        pseR <= largePageEn;
      end
      if (ctl.loadDir) dirEnt <= memData;
      if (ctl.loadTbl) tblEnt <= memData;
      if (ctl.commitOk) begin
        physR <= physNext;
        bigR <= sts.dirLarge;
        userR <= userNext;
        writeR <= writeNext;
        fltR <= FLT_NONE;
      end
      if (ctl.commitFlt) begin
        physR <= '0;
        bigR <= 1'b0;
        userR <= 1'b0;
        writeR <= 1'b0;
        fltR <= ctl.fltKind;
      end
    end
  end

  assign dirAddr = ({baseR, 12'h000} + {20'h0, vaR[31:22], 2'b00}) & a20R;
  assign tblAddr = ({dirEnt[31:12], 12'h000} + {20'h0, vaR[21:12], 2'b00}) & a20R;

  assign sts.dirPresent = dirEnt[BIT_P];
  assign sts.dirLarge   = dirEnt[BIT_PS] & pseR;
  assign sts.dirRsvd    = dirEnt[BIT_LRSVD];
  assign sts.dirNeedA   = ~dirEnt[BIT_A];
  assign sts.tblPresent = tblEnt[BIT_P];

  assign finEnt = sts.dirLarge ? dirEnt : tblEnt;
  always_comb begin
    finSet = '0;
    finSet[BIT_A] = 1'b1;
    finSet[BIT_D] = storeR;
  end
  assign sts.finNeedSet = |(finSet & ~finEnt);

  assign memAddr  = ctl.selTbl ? tblAddr : dirAddr;
  assign flagAddr = (ctl.flagFin && !sts.dirLarge) ? tblAddr : dirAddr;
  assign flagOld  = ctl.flagFin ? finEnt : dirEnt;
  always_comb begin
    if (ctl.flagFin) begin
      flagSet = finSet;
    end else begin
      flagSet = '0;
      flagSet[BIT_A] = 1'b1;
    end
  end

  generate
    if (HI_W > 0) begin : g_hiBits
      assign physSmall = {{HI_W{1'b0}}, tblEnt[31:12] & a20R[31:12], vaR[11:0]};
      assign physLarge = {dirEnt[LHI_LSB +: HI_W], dirEnt[31:22] & a20R[31:22], vaR[21:0]};
    end else begin : g_noHiBits
      assign physSmall = {tblEnt[31:12] & a20R[31:12], vaR[11:0]};
      assign physLarge = {dirEnt[31:22] & a20R[31:22], vaR[21:0]};
    end
  endgenerate

  always_comb begin
    if (sts.dirLarge) begin
      physNext  = physLarge;
      userNext  = dirEnt[BIT_US];
      writeNext = dirEnt[BIT_RW] & (storeR | dirEnt[BIT_D]);
    end else begin
      physNext  = physSmall;
      userNext  = dirEnt[BIT_US] & tblEnt[BIT_US];
      writeNext = dirEnt[BIT_RW] & tblEnt[BIT_RW] & (storeR | tblEnt[BIT_D]);
    end
  end

  assign physAddr   = physR;
  assign bigPage    = bigR;
  assign userOk     = userR;
  assign writeOk    = writeR;
  assign faultValid = (fltR != FLT_NONE);
  assign faultKind  = fltR;
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [31:0]     virtAddr,
  input  logic [1:0]      accKind,
  input  logic [31:0]     tableBase,
  input  logic            largePageEn,
  input  logic [31:0]     a20Mask,
  output logic            memReq,
  output logic [31:0]     memAddr,
  input  logic            memValid,
  input  logic [31:0]     memData,
  output logic            flagReq,
  output logic [31:0]     flagAddr,
  output logic [31:0]     flagOld,
  output logic [31:0]     flagSet,
  input  logic            flagAck,
  input  logic            flagOk,
  output logic            doneStrobe,
  output logic [PA_W-1:0] physAddr,
  output logic            bigPage,
  output logic            userOk,
  output logic            writeOk,
  output logic            faultValid,
  output logic [1:0]      faultKind
);
  pwCtl_t ctl;
  pwSts_t sts;

  pw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .memValid(memValid),
    .flagAck(flagAck), .flagOk(flagOk), .sts(sts), .ctl(ctl),
    .memReq(memReq), .flagReq(flagReq), .doneStrobe(doneStrobe)
  );

  pw_dpath #(.PA_W(PA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .virtAddr(virtAddr), .accKind(accKind),
    .tableBase(tableBase), .largePageEn(largePageEn), .a20Mask(a20Mask),
    .memData(memData), .sts(sts), .memAddr(memAddr), .flagAddr(flagAddr),
    .flagOld(flagOld), .flagSet(flagSet), .physAddr(physAddr), .bigPage(bigPage),
    .userOk(userOk), .writeOk(writeOk), .faultValid(faultValid), .faultKind(faultKind)
  );
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memValid,
  input logic [31:0] memAddr,
  input logic        flagReq,
  input logic        flagAck,
  input logic [31:0] flagAddr,
  input logic [31:0] flagSet,
  input logic        doneStrobe,
  input logic        faultValid,
  input logic [1:0]  faultKind
);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagReq && !flagAck |=> flagReq && $stable(flagAddr));

  // R11
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && flagReq));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R8
  flag_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagReq |-> flagSet[5] && ((flagSet & ~32'h0000_0060) == 32'h0));

  // R2
  fault_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe && faultValid |-> (faultKind == 2'd1 || faultKind == 2'd2));
endmodule

bind pw_walker pw_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memValid(memValid), .memAddr(memAddr),
  .flagReq(flagReq), .flagAck(flagAck), .flagAddr(flagAddr), .flagSet(flagSet),
  .doneStrobe(doneStrobe), .faultValid(faultValid), .faultKind(faultKind)
);

// File: tb/tb_pw_walker.sv
module tb_pw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] P = 32'h1, RW = 32'h2, US = 32'h4, AC = 32'h20, DT = 32'h40, PS = 32'h80;

  logic clk = 0, rstN = 0, startReq = 0, largePageEn = 0;
  logic [31:0] virtAddr = 0, tableBase = 0, a20Mask = 32'hFFFF_FFFF;
  logic [1:0] accKind = 0;
  logic memReq, memValid, flagReq, flagAck, flagOk, doneStrobe, bigPage, userOk, writeOk, faultValid;
  logic [31:0] memAddr, memData, flagAddr, flagOld, flagSet;
  logic [39:0] physAddr;
  logic [1:0] faultKind;

  int nChk = 0, nBad = 0, cyc = 0;
  int memLat = 0, waitCnt = 0, nReads = 0, nFlags = 0, failNext = 0;
  logic [31:0] interfere = 0;
  logic [31:0] readAddr [8];
  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_walker dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .virtAddr(virtAddr), .accKind(accKind),
    .tableBase(tableBase), .largePageEn(largePageEn), .a20Mask(a20Mask),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData),
    .flagReq(flagReq), .flagAddr(flagAddr), .flagOld(flagOld), .flagSet(flagSet),
    .flagAck(flagAck), .flagOk(flagOk), .doneStrobe(doneStrobe), .physAddr(physAddr),
    .bigPage(bigPage), .userOk(userOk), .writeOk(writeOk), .faultValid(faultValid),
    .faultKind(faultKind)
  );

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    memValid = 0; memData = 0;
    forever begin
      @(negedge clk);
      memValid = 0;
      if (memReq) begin
        if (waitCnt < memLat) waitCnt++;
        else begin
          memValid = 1;
          memData = rd(memAddr);
          if (nReads < 8) readAddr[nReads] = memAddr;
          nReads++;
          waitCnt = 0;
        end
      end
    end
  end

  initial begin
    flagAck = 0; flagOk = 0;
    forever begin
      @(negedge clk);
      flagAck = 0; flagOk = 0;
      if (flagReq) begin
        nFlags++;
        flagAck = 1;
        if (failNext > 0) begin
          failNext--;
          mem[flagAddr] = rd(flagAddr) | interfere;
        end else if (rd(flagAddr) == flagOld) begin
          mem[flagAddr] = flagOld | flagSet;
          flagOk = 1;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic walk(logic [31:0] va, logic [1:0] acc, logic [31:0] base, logic pse, logic [31:0] mask);
    @(negedge clk);
    virtAddr = va; accKind = acc; tableBase = base; largePageEn = pse; a20Mask = mask;
    nReads = 0; nFlags = 0;
    for (int i = 0; i < 8; i++) readAddr[i] = 32'hDEAD_BEEF;
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    for (int i = 0; i < 3000 && !doneStrobe; i++) @(negedge clk);
    chk("R11", "done pulse seen", {63'h0, doneStrobe}, 64'h1);
  endtask

  task automatic t_reset();
    chk("R12", "doneStrobe", {63'h0, doneStrobe}, 0);
    chk("R12", "memReq", {63'h0, memReq}, 0);
    chk("R12", "flagReq", {63'h0, flagReq}, 0);
    chk("R12", "faultValid", {63'h0, faultValid}, 0);
    chk("R12", "physAddr", {24'h0, physAddr}, 0);
  endtask

  task automatic t_smallLoad();
    mem.delete(); memLat = 1;
    mem[32'h2004] = 32'h0000_3000 | P | RW | US;
    mem[32'h3014] = 32'h1234_5000 | P | RW | US;
    walk(32'h0040_5123, 2'd0, 32'h0000_2ABC, 1'b1, 32'hFFFF_FFFF);
    chk("R1", "dir read addr", {32'h0, readAddr[0]}, 64'h2004);
    chk("R6", "table read addr", {32'h0, readAddr[1]}, 64'h3014);
    chk("R10", "4K phys", {24'h0, physAddr}, 64'h12_3451_23);
    chk("R5", "dir accessed set", {32'h0, rd(32'h2004)}, {32'h0, 32'h3000 | P | RW | US | AC});
    chk("R8", "pte accessed only", {32'h0, rd(32'h3014)}, {32'h0, 32'h1234_5000 | P | RW | US | AC});
    chk("R8", "write withheld clean load", {63'h0, writeOk}, 0);
    chk("R7", "user both", {63'h0, userOk}, 1);
    chk("R3", "small page flag", {63'h0, bigPage}, 0);
    chk("R5", "flag count", nFlags, 2);
  endtask

  task automatic t_smallStore();
    mem.delete(); memLat = 3;
    mem[32'h2004] = 32'h0000_3000 | P | RW | US | AC;
    mem[32'h3014] = 32'h1234_5000 | P | RW | US;
    walk(32'h0040_5123, 2'd1, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R8", "pte accessed+dirty", {32'h0, rd(32'h3014)}, {32'h0, 32'h1234_5000 | P | RW | US | AC | DT});
    chk("R8", "store write ok", {63'h0, writeOk}, 1);
    chk("R5", "no dir update when accessed", nFlags, 1);
  endtask

  task automatic t_rights();
    mem.delete(); memLat = 0;
    mem[32'h2004] = 32'h0000_3000 | P | RW | AC;
    mem[32'h3014] = 32'h1234_5000 | P | US | AC | DT;
    walk(32'h0040_5123, 2'd0, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R7", "user AND", {63'h0, userOk}, 0);
    chk("R7", "write AND", {63'h0, writeOk}, 0);
    mem[32'h3014] = 32'h1234_5000 | P | RW | US | AC | DT;
    mem[32'h2004] = 32'h0000_3000 | P | RW | US | AC;
    walk(32'h0040_5123, 2'd2, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R7", "all rights", {62'h0, userOk, writeOk}, 64'h3);
    chk("R8", "no update when flags set", nFlags, 0);
  endtask

  task automatic t_notPresent();
    mem.delete(); memLat = 2;
    mem[32'h2004] = 32'h0000_3000 | RW;
    walk(32'h0040_5123, 2'd0, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R2", "dir absent fault", {61'h0, faultValid, faultKind}, 64'h5);
    chk("R2", "dir absent reads", nReads, 1);
    mem[32'h2004] = 32'h0000_3000 | P | AC;
    mem[32'h3014] = 32'h1234_5000;
    walk(32'h0040_5123, 2'd1, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R2", "table absent fault", {61'h0, faultValid, faultKind}, 64'h5);
    chk("R2", "table absent reads", nReads, 2);
  endtask

  task automatic t_large();
    mem.delete(); memLat = 1;
    mem[32'h200C] = 32'h0840_0000 | 32'h0015_6000 | P | RW | US | PS;
    walk(32'h00C0_1234, 2'd0, 32'h0000_2000, 1'b1, 32'hFFFF_FFFF);
    chk("R3", "large page flag", {63'h0, bigPage}, 1);
    chk("R3", "large single read", nReads, 1);
    chk("R10", "4M phys high bits", {24'h0, physAddr}, 64'hAB_0840_1234);
    chk("R8", "large entry accessed", {32'h0, rd(32'h200C)}, {32'h0, 32'h0855_6000 | P | RW | US | PS | AC});
    mem[32'h200C] = 32'h0840_0000 | 32'h0020_0000 | P | PS;
    walk(32'h00C0_1234, 2'd0, 32'h0000_2000, 1'b1, 32'hFFFF_FFFF);
    chk("R4", "reserved bit fault", {61'h0, faultValid, faultKind}, 64'h6);
    chk("R4", "no update on reserved", nFlags, 0);
  endtask

  task automatic t_pseOff();
    mem.delete(); memLat = 0;
    mem[32'h200C] = 32'h0000_5000 | P | RW | US | PS | AC;
    mem[32'h5004] = 32'h0077_7000 | P | RW | US | AC | DT;
    walk(32'h00C0_1234, 2'd0, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R3", "PS ignored: small", {63'h0, bigPage}, 0);
    chk("R3", "PS ignored: table read", {32'h0, readAddr[1]}, 64'h5004);
    chk("R10", "PS ignored phys", {24'h0, physAddr}, 64'h00_0077_7234);
  endtask

  task automatic t_a20();
    mem.delete(); memLat = 1;
    mem[32'h2004] = 32'h0010_3000 | P | RW | US | AC;
    mem[32'h3014] = 32'h1234_5000 | P | RW | US | AC | DT;
    walk(32'h0040_5123, 2'd0, 32'h0010_2000, 1'b0, 32'hFFEF_FFFF);
    chk("R1", "masked dir addr", {32'h0, readAddr[0]}, 64'h2004);
    chk("R6", "masked table addr", {32'h0, readAddr[1]}, 64'h3014);
    chk("R10", "masked frame", {24'h0, physAddr}, 64'h00_1224_5123);
  endtask

  task automatic t_dirRace();
    mem.delete(); memLat = 2;
    mem[32'h2004] = 32'h0000_3000 | P | RW | US;
    mem[32'h3014] = 32'h1234_5000 | P | RW | US;
    failNext = 1; interfere = AC;
    walk(32'h0040_5123, 2'd0, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R5", "dir re-read count", nReads, 3);
    chk("R5", "second read is dir", {32'h0, readAddr[1]}, 64'h2004);
    chk("R5", "phys after re-read", {24'h0, physAddr}, 64'h00_1234_5123);
  endtask

  task automatic t_finRace();
    mem.delete(); memLat = 1;
    mem[32'h2004] = 32'h0000_3000 | P | RW | US | AC;
    mem[32'h3014] = 32'h1234_5000 | P | RW | US;
    failNext = 1; interfere = DT;
    walk(32'h0040_5123, 2'd1, 32'h0000_2000, 1'b0, 32'hFFFF_FFFF);
    chk("R9", "restart read count", nReads, 4);
    chk("R9", "third read is dir", {32'h0, readAddr[2]}, 64'h2004);
    chk("R9", "pte final flags", {32'h0, rd(32'h3014)}, {32'h0, 32'h1234_5000 | P | RW | US | AC | DT});
    chk("R9", "no fault", {63'h0, faultValid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_smallLoad();
    t_smallStore();
    t_rights();
    t_notPresent();
    t_large();
    t_pseOff();
    t_a20();
    t_dirRace();
    t_finRace();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule